// File: doc/BRIEF.md
# Guest Preemption Timer and Exit Arbiter

This block counts down a budget of ticks while a guest runs and raises a timer exit request when the count reaches zero. On guest entry, the hypervisor side pulses a load strobe with the starting value. A tick-enable input, derived elsewhere, paces the countdown. An expiry that has fired stays pending until the exit is acknowledged, or until a new load replaces it.

The timer request is gated by the core's power state and activity state. A deep C-state, a shutdown state or a wait-for-startup state blocks the timer. Counting is paused while blocked. An expiry that is already pending waits and fires as soon as the core becomes eligible again. The block also ranks the timer against two neighbouring sources: a debug-trap request ranks above it and an NMI-window request ranks below it. It presents the winner as one request with a reason code. When a live timer exit finds the core halted or in monitor-wait, the block raises a wake signal.

The control path is a three-state machine. `S_IDLE` means no timer is armed. `S_RUN` means it is counting. `S_FIRED` means an expiry is pending. The transitions are:
- `load` goes from any state to `S_RUN`.
- `expire` goes from `S_RUN` to `S_FIRED` when the counter reads zero.
- `ack` goes from `S_RUN` or `S_FIRED` to `S_IDLE` when a granted timer exit is acknowledged.

Top module: `guest_timer_arb`

## Requirements
- R1: A load strobe writes `load_val` into the counter. Each cycle with `tick_en` high, an armed timer and an eligible core, the counter drops by one.
- R2: From the cycle after the counter reaches zero, the timer exit is requested (reason 2). The counter then holds at zero.
- R3: A load value of zero requests the timer exit in the cycle right after the strobe, provided the core is eligible.
- R4: With `cstate` above 2 (power state number, 0 = C0), no timer exit and no wake are produced, and the counter does not move.
- R5: With `act_state` 3 (shutdown) or 4 (wait-for-startup), no timer exit and no wake are produced, and the counter does not move.
- R6: When `dbg_req` is high, the reported reason is 1 (debug trap), whether or not a timer exit is pending.
- R7: A live timer exit wins over `nmiw_req`. With no timer and no debug request, `nmiw_req` gives reason 3. With no source, the reason is 0 and `exit_req` is low.
- R8: A pending timer exit stays asserted until `exit_ack` is high in a cycle whose reported reason is 2, or until a new load. Acknowledging another reason leaves it pending.
- R9: An expiry blocked by R4 or R5 fires in the first cycle the core is eligible again.
- R10: `wake` is high exactly when a timer exit is live and `act_state` is 1 (halt) or 2 (monitor-wait).
- R11: After reset, no timer is armed, `exit_req` and `wake` are low and the reason is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_stb | input | 1 | Guest-entry strobe; loads and arms the timer |
| load_val | input | 32 | Starting count |
| tick_en | input | 1 | Countdown pace pulse |
| cstate | input | 3 | Power C-state number |
| act_state | input | 3 | 0 active, 1 halt, 2 monitor-wait, 3 shutdown, 4 wait-for-startup |
| dbg_req | input | 1 | Debug-trap exit request |
| nmiw_req | input | 1 | NMI-window exit request |
| exit_ack | input | 1 | Acknowledge of the reported exit |
| exit_req | output | 1 | An exit is requested |
| exit_reason | output | 2 | 0 none, 1 debug trap, 2 timer, 3 NMI window |
| wake | output | 1 | Wake the core from halt or monitor-wait |

## Verification
The bench tests loading a zero count, where a design that waited for a tick would never expire or would expire one cycle late. It also tests holding an expiry through a deep C-state or shutdown, where a design that dropped the expiry would never fire and one that ignored the gate would fire while blocked. It acknowledges a debug-trap exit while a timer exit is pending, to catch a design that clears the timer on any acknowledge. Random mixes of all three sources and all activity states check the ranking and the wake qualification against a bench model.

// File: rtl/gta_pkg.sv
package gta_pkg;
    localparam logic [1:0] RSN_NONE  = 2'd0;
    localparam logic [1:0] RSN_DEBUG = 2'd1;
    localparam logic [1:0] RSN_TIMER = 2'd2;
    localparam logic [1:0] RSN_NMIW  = 2'd3;

    localparam logic [2:0] ACT_ACTIVE = 3'd0;
    localparam logic [2:0] ACT_HALT   = 3'd1;
    localparam logic [2:0] ACT_MWAIT  = 3'd2;
    localparam logic [2:0] ACT_SHUT   = 3'd3;
    localparam logic [2:0] ACT_SIPI   = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_FIRED = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/gta_counter.sv
module gta_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic         cnt_zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_stb)
            cnt_q <= load_val;
        else if (dec_en && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/gta_fsm.sv
module gta_fsm
    import gta_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_stb,
    input  logic cnt_zero,
    input  logic ack_tmr,
    output logic running,
    output logic tmr_pend
);
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (load_stb) state_d = S_RUN;
            S_RUN: begin
                if (load_stb)      state_d = S_RUN;
                else if (ack_tmr)  state_d = S_IDLE;
                else if (cnt_zero) state_d = S_FIRED;
            end
            S_FIRED: begin
                if (load_stb)     state_d = S_RUN;
                else if (ack_tmr) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running  = (state_q == S_RUN);
        tmr_pend = ((state_q == S_RUN) && cnt_zero) || (state_q == S_FIRED);
    end
endmodule

// File: rtl/gta_arbiter.sv
module gta_arbiter
    import gta_pkg::*;
(
    input  logic       dbg_req,
    input  logic       tmr_req,
    input  logic       nmiw_req,
    output logic       exit_req,
    output logic [1:0] exit_reason
);
    always_comb begin
        if (dbg_req)       exit_reason = RSN_DEBUG;
        else if (tmr_req)  exit_reason = RSN_TIMER;
        else if (nmiw_req) exit_reason = RSN_NMIW;
        else               exit_reason = RSN_NONE;
        exit_req = dbg_req | tmr_req | nmiw_req;
    end
endmodule

// File: rtl/guest_timer_arb.sv
module guest_timer_arb
    import gta_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int MAX_CSTATE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick_en,
    input  logic [2:0]       cstate,
    input  logic [2:0]       act_state,
    input  logic             dbg_req,
    input  logic             nmiw_req,
    input  logic             exit_ack,
    output logic             exit_req,
    output logic [1:0]       exit_reason,
    output logic             wake
);
    localparam logic [2:0] CST_LIMIT = 3'(MAX_CSTATE);

    logic eligible, running, tmr_pend, tmr_live, cnt_zero, dec_en, ack_tmr;

    assign eligible = (cstate <= CST_LIMIT) &&
                      (act_state != ACT_SHUT) && (act_state != ACT_SIPI);
    assign dec_en   = running && tick_en && eligible;
    assign tmr_live = tmr_pend && eligible;
    assign ack_tmr  = exit_ack && (exit_reason == RSN_TIMER);
    assign wake     = tmr_live && ((act_state == ACT_HALT) || (act_state == ACT_MWAIT));

    gta_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .load_val (load_val),
        .dec_en   (dec_en),
        .cnt_zero (cnt_zero)
    );

    gta_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .cnt_zero (cnt_zero),
        .ack_tmr  (ack_tmr),
        .running  (running),
        .tmr_pend (tmr_pend)
    );

    gta_arbiter u_arb (
        .dbg_req     (dbg_req),
        .tmr_req     (tmr_live),
        .nmiw_req    (nmiw_req),
        .exit_req    (exit_req),
        .exit_reason (exit_reason)
    );
endmodule

// File: rtl/gta_chk.sv
module gta_chk
    import gta_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       load_stb,
    input logic [2:0] cstate,
    input logic [2:0] act_state,
    input logic       dbg_req,
    input logic       nmiw_req,
    input logic       exit_ack,
    input logic       exit_req,
    input logic [1:0] exit_reason,
    input logic       wake
);
    logic blocked;
    assign blocked = (cstate > 3'd2) || (act_state == ACT_SHUT) || (act_state == ACT_SIPI);

    // R6
    debug_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> (exit_req && exit_reason == RSN_DEBUG));

    // R4
    cstate_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate > 3'd2) |-> (exit_reason != RSN_TIMER && !wake));

    // R5
    activity_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_state == ACT_SHUT) || (act_state == ACT_SIPI)) |-> (exit_reason != RSN_TIMER && !wake));

    // R7
    nmiw_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmiw_req && !dbg_req) |-> (exit_req && exit_reason != RSN_DEBUG));

    // R8
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_reason == RSN_TIMER && !exit_ack && !load_stb)
            |=> (exit_reason == RSN_TIMER || dbg_req || blocked));

    // R10
    wake_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (exit_reason != RSN_NONE && (act_state == ACT_HALT || act_state == ACT_MWAIT)));
endmodule

bind guest_timer_arb gta_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_stb    (load_stb),
    .cstate      (cstate),
    .act_state   (act_state),
    .dbg_req     (dbg_req),
    .nmiw_req    (nmiw_req),
    .exit_ack    (exit_ack),
    .exit_req    (exit_req),
    .exit_reason (exit_reason),
    .wake        (wake)
);

// File: tb/sim_guest_timer_arb.sv
`timescale 1ns/1ps
module sim_guest_timer_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic [31:0] load_val = '0;
    logic        tick_en = 1'b0;
    logic [2:0]  cstate = '0;
    logic [2:0]  act_state = '0;
    logic        dbg_req = 1'b0;
    logic        nmiw_req = 1'b0;
    logic        exit_ack = 1'b0;
    logic        exit_req;
    logic [1:0]  exit_reason;
    logic        wake;

    int n_chk = 0;
    int n_bad = 0;
    logic        m_arm = 1'b0;
    logic [31:0] m_cnt = '0;

    always #2 clk = ~clk;

    guest_timer_arb u0 (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_val(load_val),
        .tick_en(tick_en), .cstate(cstate), .act_state(act_state),
        .dbg_req(dbg_req), .nmiw_req(nmiw_req), .exit_ack(exit_ack),
        .exit_req(exit_req), .exit_reason(exit_reason), .wake(wake)
    );

    function automatic bit f_elig(input logic [2:0] cs, input logic [2:0] ac);
        return (cs <= 3'd2) && (ac != 3'd3) && (ac != 3'd4);
    endfunction

    function automatic logic [1:0] f_reason();
        if (dbg_req) return 2'd1;
        if (m_arm && m_cnt == 0 && f_elig(cstate, act_state)) return 2'd2;
        if (nmiw_req) return 2'd3;
        return 2'd0;
    endfunction

    function automatic bit f_wake();
        return m_arm && m_cnt == 0 && f_elig(cstate, act_state) &&
               (act_state == 3'd1 || act_state == 3'd2);
    endfunction

    task automatic check(input string tag);
        logic [1:0] er;
        bit ew;
        er = f_reason();
        ew = f_wake();
        n_chk++;
        if (exit_reason !== er || exit_req !== (er != 2'd0) || wake !== ew) begin
            n_bad++;
            $display("FAIL %s: req=%0b reason=%0d wake=%0b expected req=%0b reason=%0d wake=%0b",
                     tag, exit_req, exit_reason, wake, (er != 2'd0), er, ew);
        end
    endtask

    task automatic step(input string tag);
        logic [1:0] er;
        #1;
        check(tag);
        er = f_reason();
        @(posedge clk);
        if (load_stb) begin
            m_arm = 1'b1; m_cnt = load_val;
        end else if (exit_ack && er == 2'd2) begin
            m_arm = 1'b0;
        end else if (m_arm && tick_en && f_elig(cstate, act_state) && m_cnt != 0) begin
            m_cnt = m_cnt - 1;
        end
        @(negedge clk);
        load_stb = 0; exit_ack = 0; tick_en = 0;
    endtask

    initial begin
        #400000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        step("R11 after reset");

        // R1 R2: load 3, three ticks, then expiry
        load_stb = 1; load_val = 3; step("R1 load");
        for (int i = 0; i < 3; i++) begin tick_en = 1; step("R1 countdown"); end
        step("R2 expired");
        for (int i = 0; i < 4; i++) begin tick_en = 1; step("R2 R8 hold at zero"); end
        // R8: ack of a debug exit leaves the timer pending
        dbg_req = 1; exit_ack = 1; step("R6 R8 debug ack");
        dbg_req = 0; step("R8 still pending");
        exit_ack = 1; step("R8 timer ack");
        step("R8 cleared");

        // R3: zero load
        load_stb = 1; load_val = 0; step("R3 zero load");
        step("R3 immediate exit");
        exit_ack = 1; step("R3 ack");

        // R4 R9: deep C-state pauses and blocks
        cstate = 3'd3;
        load_stb = 1; load_val = 2; step("R4 load in C3");
        for (int i = 0; i < 5; i++) begin tick_en = 1; step("R4 paused"); end
        cstate = 3'd1;
        for (int i = 0; i < 2; i++) begin tick_en = 1; step("R9 resume count"); end
        step("R9 fires in C1");
        cstate = 3'd6; step("R4 blocked pending");
        cstate = 3'd2; step("R9 fires again");

        // R5 R10
        act_state = 3'd3; step("R5 shutdown");
        act_state = 3'd4; step("R5 wait startup");
        act_state = 3'd1; step("R10 halt wake");
        act_state = 3'd2; step("R10 mwait wake");
        act_state = 3'd0; step("R10 active no wake");
        // R7
        nmiw_req = 1; step("R7 timer over nmiw");
        exit_ack = 1; step("R7 ack timer");
        step("R7 nmiw alone");
        nmiw_req = 0;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            load_stb  = ($urandom % 16) == 0;
            load_val  = $urandom % 8;
            tick_en   = $urandom % 2;
            cstate    = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
            act_state = 3'($urandom % 5);
            dbg_req   = ($urandom % 6) == 0;
            nmiw_req  = ($urandom % 4) == 0;
            exit_ack  = ($urandom % 5) == 0;
            step("R6 R7 R9 R10 random");
        end

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule